// File: doc/BRIEF.md
# Delta-Panel Scan Timing Generator

This block derives every digital timing signal that a small active-matrix panel with built-in shift-register row and column drivers needs. It runs from one 12 MHz system clock. It produces a two-phase column clock burst and the column start pulse that precedes it. It also produces the row clock, the row start pulse and the gate enable, plus a drive-polarity flag for the video path. The panel's colour dots sit in a delta arrangement, with each row shifted by one and a half dots against its neighbours. To follow this, the column start pulse and its clock burst move by half a column-clock period on odd lines.

A field runs freely for a fixed number of lines. A one-cycle field-start strobe can restart it at any time. The two scan-direction bits pass straight through to the panel. A swap flag goes to the external colour-phase delay logic; it is raised when the horizontal scan runs right to left, because the blue and green sampling phases must then be exchanged. All positions are counted in system-clock ticks from the start of the line. The field tick is the line index times the line length plus the tick within the line, counted from the last field start.

Top module: `dpanel_scan_gen`

## Requirements
- R1: After reset, the block is at tick 0 of line 0 with field flag 0. At that point hst=0, hck1=0, hck2=1, vst=0, vck=0, en=0 and pol=0.
- R2: hck2 is always the inverse of hck1. On every line, hck1 makes exactly HCK_PERIODS pulses. Each pulse period is 2*HCK_HALF ticks, and hck1 is high for the first HCK_HALF ticks of it. Outside the burst, hck1 is low.
- R3: hst is high for exactly 2*HCK_HALF ticks. It rises HST_LEAD ticks before the first hck1 rise of the same line.
- R4: hst rises at tick HST_POS on even lines and at tick HST_POS+HCK_HALF on odd lines. The whole hck burst moves with it.
- R5: vck is low at field start and changes level once per line, at tick VCK_POS.
- R6: vst is high from tick VCK_POS+LINE_TICKS/2 of line 0 up to, but not including, the same tick of line 1. This makes it one line wide and centred on the vck change of line 1.
- R7: en is high for EN_WIDTH ticks on lines 2 to ACTIVE_LINES+1 only. It falls exactly EN_GAP ticks before that line's vck change.
- R8: pol equals line parity XOR the field flag. The flag inverts at every field boundary, so pol on line 0 differs from one field to the next.
- R9: A field_start strobe sampled on a clock edge puts the block at tick 0 of line 0 after that edge. It also clears vck and inverts the field flag once, even when the strobe falls on the last tick of a field.
- R10: Without a strobe, the field wraps to line 0 after FIELD_LINES lines, and this is a field boundary.
- R11: scan_rgt equals rgt and scan_dwn equals dwn. bg_swap equals the inverse of rgt. All three are combinational, with no delay.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous reset, active high |
| field_start | input | 1 | One-cycle field restart strobe |
| rgt | input | 1 | 1 = left-to-right column scan |
| dwn | input | 1 | 1 = top-to-bottom row scan |
| hst | output | 1 | Column shift-register start pulse |
| hck1 | output | 1 | Column clock, phase 1 |
| hck2 | output | 1 | Column clock, phase 2 |
| vst | output | 1 | Row shift-register start pulse |
| vck | output | 1 | Row clock, one change per line |
| en | output | 1 | Gate enable |
| pol | output | 1 | Video drive polarity |
| scan_rgt | output | 1 | Column direction to panel |
| scan_dwn | output | 1 | Row direction to panel |
| bg_swap | output | 1 | Blue/green phase exchange request |

## Verification
Two events can land in the same cycle: the external field-start strobe and the natural field wrap on the last tick of the last line. If both counted, the field flag would flip twice and the frame-to-frame polarity alternation would be lost. The bench drives the strobe exactly on that last tick and checks that pol on the new line 0 still differs from the previous field's line 0. A second directed collision places the strobe on the tick just before the vck change. There the restart must win, and vck is checked to be low at tick 0. Random strobes, a fixed seed and random direction bits cover the rest against a field-tick model.

// File: rtl/dpanel_scan_gen.sv
module dpanel_scan_gen #(
  parameter int LINE_TICKS   = 762,
  parameter int HCK_HALF     = 2,
  parameter int HCK_PERIODS  = 147,
  parameter int HST_POS      = 150,
  parameter int HST_LEAD     = 2,
  parameter int VCK_POS      = 120,
  parameter int EN_WIDTH     = 30,
  parameter int EN_GAP       = 66,
  parameter int ACTIVE_LINES = 228,
  parameter int FIELD_LINES  = 262
) (
  input  logic clk,
  input  logic rst,
  input  logic field_start,
  input  logic rgt,
  input  logic dwn,
  output logic hst,
  output logic hck1,
  output logic hck2,
  output logic vst,
  output logic vck,
  output logic en,
  output logic pol,
  output logic scan_rgt,
  output logic scan_dwn,
  output logic bg_swap
);
  localparam int HW        = $clog2(LINE_TICKS);
  localparam int VW        = $clog2(FIELD_LINES);
  localparam int HCK_TICKS = 2 * HCK_HALF;
  localparam int BURST     = HCK_PERIODS * HCK_TICKS;
  localparam int VST_H     = VCK_POS + LINE_TICKS / 2;
  localparam int EN_ON     = VCK_POS - EN_GAP - EN_WIDTH;
  localparam int EN_OFF    = VCK_POS - EN_GAP;

  logic [HW-1:0] h;
  logic [VW-1:0] v;
  logic fld, vck_q;

  wire line_end  = (h == HW'(LINE_TICKS - 1));
  wire field_end = line_end && (v == VW'(FIELD_LINES - 1));
  wire restart   = field_start || field_end;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      h     <= '0;
      v     <= '0;
      fld   <= 1'b0;
      vck_q <= 1'b0;
    end else if (restart) begin
      h     <= '0;
      v     <= '0;
      fld   <= ~fld;
      vck_q <= 1'b0;
    end else begin
      h <= line_end ? '0 : h + HW'(1);
      if (line_end) v <= v + VW'(1);
      if (h == HW'(VCK_POS - 1)) vck_q <= ~vck_q;
    end
  end

  int a, p, hi, vi;
  always_comb begin
    hi   = int'(h);
    vi   = int'(v);
    a    = hi - HST_POS - (v[0] ? HCK_HALF : 0);
    p    = a - HST_LEAD;
    hst  = (a >= 0) && (a < HCK_TICKS);
    hck1 = (p >= 0) && (p < BURST) && ((p % HCK_TICKS) < HCK_HALF);
    vst  = (vi == 0 && hi >= VST_H) || (vi == 1 && hi < VST_H);
    en   = (vi >= 2) && (vi <= ACTIVE_LINES + 1) && (hi >= EN_ON) && (hi < EN_OFF);
  end

  assign hck2     = ~hck1;
  assign vck      = vck_q;
  assign pol      = v[0] ^ fld;
  assign scan_rgt = rgt;
  assign scan_dwn = dwn;
  assign bg_swap  = ~rgt;
endmodule

// File: rtl/dpanel_scan_chk.sv
module dpanel_scan_chk #(
  parameter int LINE_TICKS = 762
) (
  input logic clk,
  input logic rst,
  input logic field_start,
  input logic hst,
  input logic hck1,
  input logic vst,
  input logic vck,
  input logic en,
  input logic pol
);
  int vst_run;
  always_ff @(posedge clk or posedge rst)
    if (rst) vst_run <= 0;
    else     vst_run <= vst ? vst_run + 1 : 0;

  assert_hck1_min_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(hck1) && !field_start |=> hck1);
  assert_hck1_max_R2: assert property (@(posedge clk) disable iff (rst)
    hck1 && $past(hck1) |=> !hck1);
  assert_hst_lead_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(hst) |-> !hck1);
  assert_pol_in_line_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(hst) |-> $stable(pol));
  assert_vst_one_line_R6: assert property (@(posedge clk) disable iff (rst)
    vst |-> vst_run < LINE_TICKS);
  assert_en_vck_apart_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(en) && !$past(field_start) |-> $stable(vck));
  assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
    $past(field_start) |-> !vck && !vst && !en);
endmodule

bind dpanel_scan_gen dpanel_scan_chk #(.LINE_TICKS(LINE_TICKS)) chk_i (
  .clk(clk), .rst(rst), .field_start(field_start), .hst(hst), .hck1(hck1),
  .vst(vst), .vck(vck), .en(en), .pol(pol));

// File: tb/dpanel_scan_gen_tb_top.sv
module dpanel_scan_gen_tb_top;
  localparam int L = 80, HALF = 2, NP = 10, HPOS = 20, LEAD = 2;
  localparam int VPOS = 30, EW = 5, EG = 6, A = 4, F = 8;

  logic clk = 0, rst = 1, field_start = 0, rgt = 1, dwn = 1;
  logic hst, hck1, hck2, vst, vck, en, pol, scan_rgt, scan_dwn, bg_swap;
  always #4 clk = ~clk;

  dpanel_scan_gen #(.LINE_TICKS(L), .HCK_HALF(HALF), .HCK_PERIODS(NP), .HST_POS(HPOS),
    .HST_LEAD(LEAD), .VCK_POS(VPOS), .EN_WIDTH(EW), .EN_GAP(EG), .ACTIVE_LINES(A),
    .FIELD_LINES(F)) dut_i (.*);

  int checks = 0, errors = 0;
  int ft = 0, fl = 0;
  bit done = 0;
  int rises, hst_at, en_fall, en_valid, pol0, have_pol0;
  logic p_hck1, p_hst, p_en, p_vck;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at field tick %0d", req, act, exp, ft);
    end
  endtask

  function automatic int sh(int t); return HPOS + ((t / L) % 2) * HALF; endfunction
  function automatic int e_hst(int t);
    int h = t % L; return int'(h >= sh(t) && h < sh(t) + 2 * HALF);
  endfunction
  function automatic int e_hck1(int t);
    int p = t % L - sh(t) - LEAD;
    return int'(p >= 0 && p < NP * 2 * HALF && p % (2 * HALF) < HALF);
  endfunction
  function automatic int e_vck(int t);
    return (t < VPOS) ? 0 : ((t - VPOS) / L + 1) % 2;
  endfunction
  function automatic int e_vst(int t);
    return int'(t >= VPOS + L / 2 && t < VPOS + L + L / 2);
  endfunction
  function automatic int e_en(int t);
    int v = t / L, h = t % L;
    return int'(v >= 2 && v <= A + 1 && h >= VPOS - EG - EW && h < VPOS - EG);
  endfunction

  task automatic check_all();
    int h = ft % L;
    chk("R2 hck1", int'(hck1), e_hck1(ft));
    chk("R2 hck2 inverse", int'(hck2), 1 - e_hck1(ft));
    chk("R3 hst", int'(hst), e_hst(ft));
    chk("R5 vck", int'(vck), e_vck(ft));
    chk("R6 vst", int'(vst), e_vst(ft));
    chk("R7 en", int'(en), e_en(ft));
    chk("R8 pol", int'(pol), ((ft / L) % 2) ^ fl);
    chk("R11 scan_rgt", int'(scan_rgt), int'(rgt));
    chk("R11 scan_dwn", int'(scan_dwn), int'(dwn));
    chk("R11 bg_swap", int'(bg_swap), 1 - int'(rgt));
    if (h == 0) begin
      rises = 0; hst_at = -1; en_valid = 0;
      if (ft == 0) begin
        if (have_pol0) chk("R8 line0 pol alternates", int'(pol), 1 - pol0);
        pol0 = int'(pol); have_pol0 = 1;
      end
    end else begin
      if (hck1 && !p_hck1) rises++;
      if (hst && !p_hst) hst_at = h;
      if (!en && p_en) begin en_fall = ft; en_valid = 1; end
      if (vck != p_vck && en_valid) begin
        chk("R7 en fall to vck gap", ft - en_fall, EG);
        en_valid = 0;
      end
      if (h == L - 1) begin
        chk("R2 hck1 pulses per line", rises, NP);
        chk("R4 hst rise tick", hst_at, sh(ft));
      end
    end
    p_hck1 = hck1; p_hst = hst; p_en = en; p_vck = vck;
  endtask

  task automatic cycle(input logic stb);
    @(negedge clk);
    check_all();
    field_start = stb;
    rgt = 1'($urandom % 2);
    dwn = 1'($urandom % 2);
    if (stb || ft == F * L - 1) begin ft = 0; fl ^= 1; end
    else ft++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got 0 expected 1 (run ended)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    have_pol0 = 0; rises = 0; hst_at = -1; en_valid = 0; en_fall = 0; pol0 = 0;
    repeat (3) @(negedge clk);
    chk("R1 hst", int'(hst), 0);
    chk("R1 hck1", int'(hck1), 0);
    chk("R1 hck2", int'(hck2), 1);
    chk("R1 vst", int'(vst), 0);
    chk("R1 vck", int'(vck), 0);
    chk("R1 en", int'(en), 0);
    chk("R1 pol", int'(pol), 0);
    p_hck1 = hck1; p_hst = hst; p_en = en; p_vck = vck;
    pol0 = int'(pol); have_pol0 = 1;
    rst = 0; ft = 1;
    // R10: free-running wraps over two full fields
    repeat (2 * F * L) cycle(1'b0);
    // R9: strobe on the last tick of a field counts once
    while (ft != F * L - 1) cycle(1'b0);
    cycle(1'b1);
    repeat (3 * L) cycle(1'b0);
    // R9: strobe on the tick before a vck change on an EN line
    while (ft != 3 * L + VPOS - 1) cycle(1'b0);
    cycle(1'b1);
    repeat (F * L) cycle(1'b0);
    // random strobes
    repeat (12000) cycle(($urandom % 700) == 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule